// File: doc/BRIEF.md
# Turn-Restricted Mesh Route Selector

This block computes the next hop for the head flit of a packet at one router of a two-dimensional mesh. It takes the router's own coordinates, the destination coordinates and a two-bit routing policy code. Each policy is a turn restriction that keeps the network free of deadlock, and each still allows some adaptive choice. The block first forms a one-hot-per-port candidate mask that holds only the distance-reducing directions the policy permits. It then chooses one candidate whose downstream free/credit flag is set and presents that choice on a registered output with a valid/ready handshake.

Requests arrive on a valid/ready input. The block holds a captured request in a wait state until one of its permitted ports is free. It never substitutes a port outside the candidate mask.

The controller has three states:
- `ST_IDLE` accepts a request: `in_valid` moves it to `ST_SEEK`.
- `ST_SEEK` looks for a free candidate. It stays in `ST_SEEK` while no candidate is free. It registers the choice and moves to `ST_HOLD` once one is free.
- `ST_HOLD` presents the result and returns to `ST_IDLE` on `out_ready`.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Port bit positions are East=0 (X+1), West=1 (X-1), North=2 (Y+1), South=3 (Y-1) and Local=4. Mode code 0 (dimension-ordered) offers only East or West while X differs, and only North or South once X matches.
- R3: Mode code 1 (west-first) offers only West while the destination lies to the West. Otherwise it offers every needed direction among East, North and South.
- R4: Mode code 2 (north-last) offers every needed direction among East, West and South. It offers North only when North is the sole direction still needed.
- R5: Mode code 3 (negative-first) offers the needed directions among West and South while either is needed. Otherwise it offers the needed directions among East and North.
- R6: When the destination equals the current node, the candidate mask is Local only (5'b10000).
- R7: Among candidates whose `port_free` bit is set, the chosen port follows the priority East, North, West, South, Local.
- R8: While no candidate is free, `out_valid` stays 0. The request is kept and is resolved once a candidate frees up. `out_port` is always a single bit inside `out_cand`.
- R9: A request accepted at one clock edge yields `out_valid`=1 after the next edge when a candidate is free. `in_ready` is 0 from acceptance until the result is taken.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_port` and `out_cand` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| cur_x | input | XW | Current node X coordinate |
| cur_y | input | YW | Current node Y coordinate |
| dst_x | input | XW | Destination X coordinate |
| dst_y | input | YW | Destination Y coordinate |
| mode | input | 2 | Routing policy code |
| port_free | input | 5 | Per-port free/credit flags, bit order as in R2 |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision taken |
| out_port | output | 5 | One-hot chosen port |
| out_cand | output | 5 | Permitted minimal port mask |

## Verification
Every pairing of current node, destination and policy on the default 4 x 4 mesh is routed once, so all relative positions in each quadrant, on each axis and at the same node are covered under all four policies. For each route the free flags come from an arithmetic sequence. Some routes therefore have several free candidates, which separates the priority order from the mask. Others have none free, which exercises the hold-until-free path before the flags are opened. On a subset of routes the consumer delays `out_ready`, which shows whether the presented result stays stable.

// File: rtl/route_pkg.sv
package route_pkg;
    localparam int NPORT   = 5;
    localparam int P_EAST  = 0;
    localparam int P_WEST  = 1;
    localparam int P_NORTH = 2;
    localparam int P_SOUTH = 3;
    localparam int P_LOCAL = 4;

    typedef enum logic [1:0] {
        RM_XY         = 2'd0,
        RM_WEST_FIRST = 2'd1,
        RM_NORTH_LAST = 2'd2,
        RM_NEG_FIRST  = 2'd3
    } route_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_HOLD = 2'd2
    } route_state_e;
endpackage

// File: rtl/route_cand.sv
module route_cand
    import route_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    input  logic [XW-1:0]    dst_x,
    input  logic [YW-1:0]    dst_y,
    input  route_mode_e      mode,
    output logic [NPORT-1:0] cand
);
    logic go_e, go_w, go_n, go_s;

    always_comb begin
        go_e = dst_x > cur_x;
        go_w = dst_x < cur_x;
        go_n = dst_y > cur_y;
        go_s = dst_y < cur_y;
    end

    always_comb begin
        cand = '0;
        unique case (mode)
            RM_XY: begin
                if (go_e || go_w) begin
                    cand[P_EAST] = go_e;
                    cand[P_WEST] = go_w;
                end else begin
                    cand[P_NORTH] = go_n;
                    cand[P_SOUTH] = go_s;
                end
            end
            RM_WEST_FIRST: begin
                if (go_w) begin
                    cand[P_WEST] = 1'b1;
                end else begin
                    cand[P_EAST]  = go_e;
                    cand[P_NORTH] = go_n;
                    cand[P_SOUTH] = go_s;
                end
            end
            RM_NORTH_LAST: begin
                if (go_e || go_w || go_s) begin
                    cand[P_EAST]  = go_e;
                    cand[P_WEST]  = go_w;
                    cand[P_SOUTH] = go_s;
                end else begin
                    cand[P_NORTH] = go_n;
                end
            end
            RM_NEG_FIRST: begin
                if (go_w || go_s) begin
                    cand[P_WEST]  = go_w;
                    cand[P_SOUTH] = go_s;
                end else begin
                    cand[P_EAST]  = go_e;
                    cand[P_NORTH] = go_n;
                end
            end
            default: cand = '0;
        endcase
        if (!(go_e || go_w || go_n || go_s)) cand = NPORT'(1) << P_LOCAL;
    end
endmodule

// File: rtl/route_pick.sv
module route_pick
    import route_pkg::*;
(
    input  logic [NPORT-1:0] cand,
    input  logic [NPORT-1:0] free,
    output logic [NPORT-1:0] grant,
    output logic             any
);
    logic [NPORT-1:0] ok;

    always_comb begin
        ok    = cand & free;
        grant = '0;
        if      (ok[P_EAST])  grant[P_EAST]  = 1'b1;
        else if (ok[P_NORTH]) grant[P_NORTH] = 1'b1;
        else if (ok[P_WEST])  grant[P_WEST]  = 1'b1;
        else if (ok[P_SOUTH]) grant[P_SOUTH] = 1'b1;
        else if (ok[P_LOCAL]) grant[P_LOCAL] = 1'b1;
        any = |ok;
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import route_pkg::*;
#(
    parameter int MESH_W = 4,
    parameter int MESH_H = 4,
    localparam int XW = (MESH_W > 1) ? $clog2(MESH_W) : 1,
    localparam int YW = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    input  logic [XW-1:0]    dst_x,
    input  logic [YW-1:0]    dst_y,
    input  logic [1:0]       mode,
    input  logic [NPORT-1:0] port_free,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [NPORT-1:0] out_port,
    output logic [NPORT-1:0] out_cand
);
    route_state_e     state, state_nx;
    logic [XW-1:0]    rq_cx, rq_dx;
    logic [YW-1:0]    rq_cy, rq_dy;
    route_mode_e      rq_mode;
    logic [NPORT-1:0] cand, grant;
    logic             pick_any;

    route_cand #(.XW(XW), .YW(YW)) u_cand (
        .cur_x (rq_cx),
        .cur_y (rq_cy),
        .dst_x (rq_dx),
        .dst_y (rq_dy),
        .mode  (rq_mode),
        .cand  (cand)
    );

    route_pick u_pick (
        .cand  (cand),
        .free  (port_free),
        .grant (grant),
        .any   (pick_any)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_SEEK;
            ST_SEEK: if (pick_any)  state_nx = ST_HOLD;
            ST_HOLD: if (out_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_cx    <= '0;
            rq_cy    <= '0;
            rq_dx    <= '0;
            rq_dy    <= '0;
            rq_mode  <= RM_XY;
            out_port <= '0;
            out_cand <= '0;
        end else begin
            if (state == ST_IDLE && in_valid) begin
                rq_cx   <= cur_x;
                rq_cy   <= cur_y;
                rq_dx   <= dst_x;
                rq_dy   <= dst_y;
                rq_mode <= route_mode_e'(mode);
            end
            if (state == ST_SEEK && pick_any) begin
                out_port <= grant;
                out_cand <= cand;
            end
        end
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_HOLD);

    a_r8_port_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_port) == 1 && (out_port & ~out_cand) == '0));

    a_r7_chosen_was_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (($past(port_free) & out_port) != '0));

    a_r8_wait_no_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK && !pick_any) |=> !out_valid);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_cand)));

    a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r6_local_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cand[P_LOCAL]) |-> (out_cand == (NPORT'(1) << P_LOCAL)));
endmodule

// File: tb/mesh_route_unit_tb.sv
module mesh_route_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [1:0] mode = '0;
    logic [4:0] port_free = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [4:0] out_port, out_cand;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_route_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .mode(mode), .port_free(port_free), .out_valid(out_valid),
        .out_ready(out_ready), .out_port(out_port), .out_cand(out_cand)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected mask from signed offsets. Bits: E0 W1 N2 S3 L4.
    function automatic logic [4:0] want_mask(int m, int cx, int cy, int ex, int ey);
        int ddx = ex - cx;
        int ddy = ey - cy;
        logic e = ddx > 0, w = ddx < 0, n = ddy > 0, s = ddy < 0;
        if (ddx == 0 && ddy == 0) return 5'b10000;
        case (m)
            0: return (ddx != 0) ? {3'b000, w, e} : {1'b0, s, n, 2'b00};
            1: return w ? 5'b00010 : {1'b0, s, n, 1'b0, e};
            2: return (e | w | s) ? {1'b0, s, 1'b0, w, e} : 5'b00100;
            default: return (w | s) ? {1'b0, s, 1'b0, w, 1'b0} : {2'b00, n, 1'b0, e};
        endcase
    endfunction

    function automatic logic [4:0] want_pick(logic [4:0] ok);
        if (ok[0]) return 5'b00001;
        if (ok[2]) return 5'b00100;
        if (ok[1]) return 5'b00010;
        if (ok[3]) return 5'b01000;
        if (ok[4]) return 5'b10000;
        return 5'b00000;
    endfunction

    function automatic string tag_for(int m, logic [4:0] mk);
        if (mk == 5'b10000) return "R6";
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        chk("R1 in_ready", {7'd0, in_ready}, 8'd1);
        chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 16; c++) begin
                for (int d = 0; d < 16; d++) begin
                    logic [4:0] mk, fr, okm;
                    mk  = want_mask(m, c % 4, c / 4, d % 4, d / 4);
                    fr  = 5'((idx * 11 + 3) % 32);
                    okm = mk & fr;
                    @(negedge clk);
                    port_free = fr;
                    mode = 2'(m);
                    cur_x = 2'(c % 4); cur_y = 2'(c / 4);
                    dst_x = 2'(d % 4); dst_y = 2'(d / 4);
                    in_valid = 1'b1;
                    @(negedge clk);
                    in_valid = 1'b0;
                    if (idx % 97 == 0) chk("R9 in_ready low when busy", {7'd0, in_ready}, 8'd0);
                    @(negedge clk);
                    if (okm != 0) begin
                        chk("R9 valid one cycle after accept", {7'd0, out_valid}, 8'd1);
                        chk({tag_for(m, mk), " mask"}, {3'd0, out_cand}, {3'd0, mk});
                        chk("R7 priority pick", {3'd0, out_port}, {3'd0, want_pick(okm)});
                    end else begin
                        chk("R8 no valid without free candidate", {7'd0, out_valid}, 8'd0);
                        @(negedge clk);
                        chk("R8 still waiting", {7'd0, out_valid}, 8'd0);
                        port_free = 5'b11111;
                        @(negedge clk);
                        chk("R8 resolves after free", {7'd0, out_valid}, 8'd1);
                        chk({tag_for(m, mk), " mask"}, {3'd0, out_cand}, {3'd0, mk});
                        chk("R7 priority pick all free", {3'd0, out_port}, {3'd0, want_pick(mk)});
                    end
                    if (idx % 5 == 0) begin
                        logic [4:0] held;
                        held = out_port;
                        port_free = ~port_free;
                        @(negedge clk);
                        chk("R10 valid held", {7'd0, out_valid}, 8'd1);
                        chk("R10 port held", {3'd0, out_port}, {3'd0, held});
                    end
                    out_ready = 1'b1;
                    @(negedge clk);
                    out_ready = 1'b0;
                    chk("R9 back to idle", {6'd0, in_ready, out_valid}, 8'd2);
                    idx++;
                end
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule